// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block sits beside the atomic-operation issue path of a core cluster. For every atomic memory operation it decides whether the operation should execute in the requesting core's L1 cache (`local`) or be shipped to the shared outer cache level (`far`). It learns the decision separately for each cache block. A block that one CPU keeps hitting in an unbroken run is handled locally. A block that is contended or newly seen is handled far away, so that the cache line does not move between cores.

The learning state is a direct-mapped table. The low bits of the block address select an entry, and the remaining address bits are kept as a tag. Each entry holds a valid bit, the tag, the ID of the CPU that touched the block most recently and a saturating run counter. A request is a single-cycle strobe carrying a block address and a CPU ID. The answer comes back registered one cycle later. The table entry is rewritten on the same clock edge that captures the answer, so a request in the next cycle already sees the new state. A synchronous invalidate input empties the whole table in one cycle.

Top module: `apred_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid` is 0. After reset every entry is empty, so the first request to any block is answered far.
- R2: The run counter is `CNT_W` bits wide and stops at 2^CNT_W-1 without wrapping. A block under an unbroken single-CPU run therefore stays local indefinitely.
- R3: A request that hits an entry (valid and tag equal) from the stored CPU increments the counter. It is answered local (`rsp_local`=1) exactly when the updated count is strictly greater than `THRESH`. With THRESH=3, the first four accesses of a run are far and the fifth and later ones are local.
- R4: A hit from a CPU other than the stored one sets the counter to 0, stores the new CPU ID and is answered far.
- R5: Two CPUs that alternate on the same block are always answered far.
- R6: A request that misses (entry empty or tag different) allocates the entry with the new tag, the requester as owner and a count of 0, and is answered far. The previous occupant of that index is lost.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise. `rsp_local` is 0 whenever `rsp_valid` is 0. In `rsp_local`, 1 means local and 0 means far.
- R8: Back-to-back requests to one entry in consecutive cycles each see the update made by the previous request.
- R9: `inval` high for one cycle empties every entry. A request in the same cycle is answered far and allocates nothing.
- R10: Entries at different indices learn independently. Interleaved traffic to one index does not change the decisions at another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval | input | 1 | Empty the whole table this cycle |
| req_valid | input | 1 | Atomic operation request strobe |
| req_addr | input | ADDR_W | Cache-block address of the operation |
| req_cpu | input | CPU_W | ID of the requesting CPU |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_local | output | 1 | 1 = execute in L1, 0 = send to the outer cache |

## Verification
The bench uses the default build: a 16-bit block address, 8 entries, 2-bit CPU IDs, a 3-bit counter and THRESH=3. With these values a run changes to local after only four far answers. Saturation at 7 is reached within a few more accesses, so a counter that wrapped would drop back to far and be caught. The small table makes index aliasing easy to arrange with addresses that differ only above bit 2, which exercises tag replacement and the independence of entries.

// File: rtl/apred_pkg.sv
package apred_pkg;

    typedef enum logic {
        PLACE_FAR   = 1'b0,
        PLACE_LOCAL = 1'b1
    } place_e;

    typedef enum logic [1:0] {
        LOOK_MISS  = 2'd0,
        LOOK_SAME  = 2'd1,
        LOOK_OTHER = 2'd2
    } look_e;

    function automatic int unsigned sat_limit(input int unsigned width);
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/apred_split.sv
module apred_split #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        idx = addr[IDX_W-1:0];
        tag = addr[ADDR_W-1:IDX_W];
    end
endmodule

// File: rtl/apred_table.sv
module apred_table #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13,
    parameter int CPU_W = 2,
    parameter int CNT_W = 3,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CPU_W-1:0] rd_cpu,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [CNT_W-1:0] wr_cnt
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [CPU_W-1:0]   cpu_q [ENTRIES];
    logic [CNT_W-1:0]   cnt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e] <= wr_tag;
                cpu_q[e] <= wr_cpu;
                cnt_q[e] <= wr_cnt;
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_cpu   = cpu_q[rd_idx];
        rd_cnt   = cnt_q[rd_idx];
    end

    // R9: one cycle of clear leaves no entry valid
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (valid_q == '0));

    // R1: reset leaves no entry valid
    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> (valid_q == '0));

    // R6: a written entry is valid in the next cycle unless cleared
    a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/apred_decide.sv
module apred_decide
    import apred_pkg::*;
#(
    parameter int TAG_W  = 13,
    parameter int CPU_W  = 2,
    parameter int CNT_W  = 3,
    parameter int THRESH = 3
) (
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [CPU_W-1:0] ent_cpu,
    input  logic [CNT_W-1:0] ent_cnt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [CPU_W-1:0] req_cpu,
    output look_e            look,
    output logic [CNT_W-1:0] new_cnt,
    output place_e           place
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(sat_limit(CNT_W));

    always_comb begin
        if (!ent_valid || ent_tag != req_tag) begin
            look = LOOK_MISS;
        end else if (ent_cpu == req_cpu) begin
            look = LOOK_SAME;
        end else begin
            look = LOOK_OTHER;
        end
    end

    always_comb begin
        unique case (look)
            LOOK_SAME: new_cnt = (ent_cnt == CNT_TOP) ? CNT_TOP : ent_cnt + 1'b1;
            default:   new_cnt = '0;
        endcase
    end

    always_comb begin
        if (look == LOOK_SAME && int'(new_cnt) > THRESH) begin
            place = PLACE_LOCAL;
        end else begin
            place = PLACE_FAR;
        end
    end

    // R3/R4/R6: only a same-CPU hit may be placed locally
    always_comb begin
        a_r3_local_only_same: assert (place != PLACE_LOCAL || look == LOOK_SAME);
    end

    // R2: the counter never falls on a same-CPU hit
    always_comb begin
        a_r2_no_wrap: assert (look != LOOK_SAME || new_cnt >= ent_cnt);
    end
endmodule

// File: rtl/apred_top.sv
module apred_top
    import apred_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int CPU_W  = 2,
    parameter int CNT_W  = 3,
    parameter int THRESH = 3,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output logic              rsp_valid,
    output logic              rsp_local
);
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    logic [CPU_W-1:0] ent_cpu;
    logic [CNT_W-1:0] ent_cnt;
    look_e            look;
    logic [CNT_W-1:0] new_cnt;
    place_e           place;
    logic             upd;

    assign upd = req_valid && !inval;

    apred_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split (
        .addr (req_addr),
        .idx  (idx),
        .tag  (tag)
    );

    apred_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CPU_W(CPU_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .clr      (inval),
        .rd_idx   (idx),
        .rd_valid (ent_valid),
        .rd_tag   (ent_tag),
        .rd_cpu   (ent_cpu),
        .rd_cnt   (ent_cnt),
        .wr_en    (upd),
        .wr_idx   (idx),
        .wr_tag   (tag),
        .wr_cpu   (req_cpu),
        .wr_cnt   (new_cnt)
    );

    apred_decide #(.TAG_W(TAG_W), .CPU_W(CPU_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_decide (
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_cpu   (ent_cpu),
        .ent_cnt   (ent_cnt),
        .req_tag   (tag),
        .req_cpu   (req_cpu),
        .look      (look),
        .new_cnt   (new_cnt),
        .place     (place)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_local <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_local <= upd && (place == PLACE_LOCAL);
        end
    end

    // R7: a request is answered in the next cycle
    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R7: no answer without a request
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_local));

    // R9: a request that meets an invalidate is answered far
    a_r9_inval_far: assert property (@(posedge clk) disable iff (rst)
        (inval && req_valid) |=> (rsp_valid && !rsp_local));

    // R6: a miss is answered far
    a_r6_miss_far: assert property (@(posedge clk) disable iff (rst)
        (req_valid && look == LOOK_MISS) |=> !rsp_local);

    // R4: a hit from another CPU is answered far
    a_r4_other_far: assert property (@(posedge clk) disable iff (rst)
        (req_valid && look == LOOK_OTHER) |=> !rsp_local);
endmodule

// File: tb/apred_top_tb.sv
module apred_top_tb;
    localparam int ADDR_W  = 16;
    localparam int IDX_W   = 3;
    localparam int CPU_W   = 2;
    localparam int CNT_W   = 3;
    localparam int THRESH  = 3;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              inval = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CPU_W-1:0]  req_cpu = '0;
    logic              rsp_valid;
    logic              rsp_local;

    int checks = 0;
    int failures = 0;

    int m_valid [ENTRIES];
    int m_tag   [ENTRIES];
    int m_cpu   [ENTRIES];
    int m_cnt   [ENTRIES];

    always #4 clk = ~clk;

    apred_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CPU_W(CPU_W),
                .CNT_W(CNT_W), .THRESH(THRESH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .inval     (inval),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_cpu   (req_cpu),
        .rsp_valid (rsp_valid),
        .rsp_local (rsp_local)
    );

    task automatic check(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Drive one cycle (called at a falling edge), model it, check the answer one edge later.
    task automatic step(input bit rq, input int addr, input int cpu, input bit inv, input string tag);
        bit ev;
        bit el;
        int ix;
        int tg;
        req_valid = rq;
        req_addr  = ADDR_W'(addr);
        req_cpu   = CPU_W'(cpu);
        inval     = inv;
        ev = rq;
        el = 1'b0;
        ix = addr % ENTRIES;
        tg = addr / ENTRIES;
        if (inv) begin
            for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
        end else if (rq) begin
            if (m_valid[ix] != 0 && m_tag[ix] == tg) begin
                if (m_cpu[ix] == cpu) begin
                    if (m_cnt[ix] < CMAX) m_cnt[ix] = m_cnt[ix] + 1;
                    el = (m_cnt[ix] > THRESH);
                end else begin
                    m_cnt[ix] = 0;
                    m_cpu[ix] = cpu;
                end
            end else begin
                m_valid[ix] = 1;
                m_tag[ix]   = tg;
                m_cpu[ix]   = cpu;
                m_cnt[ix]   = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "rsp_valid", rsp_valid, ev);
        check(tag, "rsp_local", rsp_local, el);
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_cpu[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", rsp_valid, 1'b0);
        rst = 1'b0;
        step(0, 0, 0, 0, "R1");
        // R1: first touch of a block is far
        step(1, 'h0011, 1, 0, "R1");
        // R3/R8: back-to-back single CPU run on one block
        for (int k = 0; k < 6; k++) step(1, 'h0011, 1, 0, "R3");
        // R2: long run, counter saturates and stays local
        for (int k = 0; k < 10; k++) step(1, 'h0011, 1, 0, "R2");
        // R4: different CPU breaks the run
        step(1, 'h0011, 2, 0, "R4");
        for (int k = 0; k < 5; k++) step(1, 'h0011, 2, 0, "R4");
        // R7: idle cycles give no answer
        step(0, 'h0011, 2, 0, "R7");
        step(0, 'h0011, 2, 0, "R7");
        // R5: alternating CPUs stay far
        for (int k = 0; k < 12; k++) step(1, 'h0022, k % 2, 0, "R5");
        // R6: tag alias evicts the owner of the index
        for (int k = 0; k < 5; k++) step(1, 'h0033, 3, 0, "R6");
        step(1, 'h0433, 3, 0, "R6");
        step(1, 'h0033, 3, 0, "R6");
        for (int k = 0; k < 5; k++) step(1, 'h0033, 3, 0, "R6");
        // R10: interleaved traffic at two indices learns independently
        for (int k = 0; k < 14; k++) begin
            if (k % 2 == 0) step(1, 'h0044, 0, 0, "R10");
            else            step(1, 'h0045, k % 4, 0, "R10");
        end
        // R8: gaps between requests still keep state
        step(1, 'h0044, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(1, 'h0044, 0, 0, "R8");
        // R9: invalidate with a concurrent request
        step(1, 'h0044, 0, 1, "R9");
        step(1, 'h0044, 0, 0, "R9");
        step(1, 'h0011, 2, 0, "R9");
        for (int k = 0; k < 5; k++) step(1, 'h0044, 0, 0, "R9");
        // R9: invalidate alone, then relearn
        step(0, 0, 0, 1, "R9");
        for (int k = 0; k < 6; k++) step(1, 'h0011, 2, 0, "R9");
        step(0, 0, 0, 0, "R7");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule